// File: doc/BRIEF.md
# SPI Slave Shifter, Clock Phase Zero

This block is an 8-bit serial slave that runs from a fast system clock and works with clock phase zero. The serial clock, data-in and select lines come in asynchronously. Each one passes through a two-flop synchronizer before an edge detector turns it into single-cycle events. A polarity input sets which serial clock edge opens a bit. A bit-order input picks most-significant-bit-first or least-significant-bit-first, and this order applies to both directions.

When select goes low, the block loads the transmit byte and enables its data output. It shows the first transmit bit on that output before any clock edge arrives. On the first edge of each bit it samples the data input. On the second edge it shifts the sampled bit into the receive register and moves the next transmit bit onto the output. After eight bits it updates the received byte and sets a sticky receive-full flag, which the host clears with a one-cycle acknowledge. Select must go high between bytes. If more bits are clocked in without that, the extra bits are dropped and a framing-error flag is raised. If select goes high early, the partial byte is thrown away.

The serial clock must run at no more than a quarter of the system clock rate.

Top module: `spi0_slave`

## Requirements
- R1: After reset, miso_oe, miso, rx_full and frame_err are 0 and rx_byte is 8'h00.
- R2: Within four system clocks of select falling, and before any serial clock edge, miso_oe is 1. miso then carries bit 7 of tx_byte when cfg_lsb_first=0, or bit 0 when cfg_lsb_first=1.
- R3: The first edge of a bit is the rising edge when cfg_cpol=0 and the falling edge when cfg_cpol=1. The data input is sampled on that edge.
- R4: Each second edge moves the next transmit bit onto miso. Over eight bits, tx_byte goes out in the selected order: bit 7 down to bit 0, or bit 0 up to bit 7.
- R5: The received byte is assembled in the same order. With cfg_lsb_first=0 the first bit received becomes bit 7; with cfg_lsb_first=1 it becomes bit 0.
- R6: The second edge of the eighth bit updates rx_byte and sets rx_full. rx_full stays set until rx_ack is high for one cycle, and rx_byte changes only when a byte completes.
- R7: While select is high, miso_oe is 0 and miso is 0.
- R8: A first edge after eight bits, while select is still low, is ignored: rx_byte keeps the eight-bit value and frame_err is set. frame_err clears on the next select fall.
- R9: If select rises before eight bits, the partial byte is discarded. rx_full is not set, rx_byte is unchanged, and the next transfer starts again from bit one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cpol | input | 1 | Serial clock polarity: 0 = rising edge opens a bit, 1 = falling edge opens a bit |
| cfg_lsb_first | input | 1 | Bit order: 0 = MSB first, 1 = LSB first |
| tx_byte | input | 8 | Byte loaded for transmission when select falls |
| rx_ack | input | 1 | Clears rx_full |
| spsck | input | 1 | Serial clock, asynchronous |
| mosi | input | 1 | Serial data in, asynchronous |
| ss_n | input | 1 | Active-low select, asynchronous |
| miso | output | 1 | Serial data out (0 when not enabled) |
| miso_oe | output | 1 | Output enable for miso; high only while selected |
| rx_byte | output | 8 | Last complete received byte |
| rx_full | output | 1 | Sticky flag for a received byte |
| frame_err | output | 1 | Extra bits arrived without select going high |

## Verification
The bench runs every combination of polarity and bit order. A design that takes the wrong edge as the first edge, or that reverses the bit order on either side, returns a mirrored or shifted byte. A design that drives the first bit from a clock edge instead of from select shows the wrong level at the pre-edge sample. A nine-bit frame checks that a missing select release leaves the byte alone and raises the error. A design that lets the ninth bit shift in would return a corrupted byte. A four-bit aborted frame followed by a full one catches a bit counter that is not reset, which would complete the byte early and misaligned.

// File: rtl/spi0_pkg.sv
package spi0_pkg;

    localparam int unsigned SPI0_DATA_W     = 8;
    localparam int unsigned SPI0_SYNC_DEPTH = 2;

    // synchronized pin bundle; ss_n idles high
    typedef struct packed {
        logic sck;
        logic mosi;
        logic ss_n;
    } spi0_pins_t;

    localparam spi0_pins_t SPI0_PINS_IDLE = '{sck: 1'b0, mosi: 1'b0, ss_n: 1'b1};

    // single-cycle events handed to the shifter
    typedef struct packed {
        logic lead;      // first edge of a bit time
        logic trail;     // second edge of a bit time
        logic sel_fall;
        logic sel_rise;
        logic din;       // synchronized data-in level
    } spi0_evt_t;

    function automatic logic spi0_edge_pick(input logic rise, input logic fall,
                                            input logic invert);
        return invert ? fall : rise;
    endfunction

endpackage

// File: rtl/spi0_sync.sv
module spi0_sync #(
    parameter int unsigned        W       = 3,
    parameter int unsigned        STAGES  = 2,
    parameter logic [W-1:0]       RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= {STAGES{RST_VAL}};
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/spi0_edge.sv
module spi0_edge
    import spi0_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cpol,
    input  spi0_pins_t cur,
    output spi0_evt_t  evt
);
    logic prev_sck;
    logic prev_ss_n;
    logic sck_rise;
    logic sck_fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_sck  <= SPI0_PINS_IDLE.sck;
            prev_ss_n <= SPI0_PINS_IDLE.ss_n;
        end else begin
            prev_sck  <= cur.sck;
            prev_ss_n <= cur.ss_n;
        end
    end

    assign sck_rise = cur.sck & ~prev_sck;
    assign sck_fall = ~cur.sck & prev_sck;

    always_comb begin
        evt.lead     = spi0_edge_pick(sck_rise, sck_fall, cpol);
        evt.trail    = spi0_edge_pick(sck_fall, sck_rise, cpol);
        evt.sel_fall = prev_ss_n & ~cur.ss_n;
        evt.sel_rise = ~prev_ss_n & cur.ss_n;
        evt.din      = cur.mosi;
    end
endmodule

// File: rtl/spi0_shifter.sv
module spi0_shifter
    import spi0_pkg::*;
#(
    parameter int unsigned W = SPI0_DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         lsb_first,
    input  logic [W-1:0] tx_byte,
    input  spi0_evt_t    evt,
    output logic         miso,
    output logic         miso_oe,
    output logic [W-1:0] rx_byte,
    output logic         rx_done,
    output logic         frame_err
);
    localparam int unsigned CNT_W = $clog2(W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(W - 1);

    logic             active;
    logic             half;
    logic             samp;
    logic [CNT_W-1:0] cnt;
    logic [W-1:0]     tx_sr;
    logic [W-1:0]     rx_sr;
    logic [W-1:0]     tx_next;
    logic [W-1:0]     rx_next;
    logic             tx_bit;

    always_comb begin
        if (lsb_first) begin
            tx_bit  = tx_sr[0];
            tx_next = {1'b0, tx_sr[W-1:1]};
            rx_next = {samp, rx_sr[W-1:1]};
        end else begin
            tx_bit  = tx_sr[W-1];
            tx_next = {tx_sr[W-2:0], 1'b0};
            rx_next = {rx_sr[W-2:0], samp};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active    <= 1'b0;
            half      <= 1'b0;
            samp      <= 1'b0;
            cnt       <= '0;
            tx_sr     <= '0;
            rx_sr     <= '0;
            rx_byte   <= '0;
            rx_done   <= 1'b0;
            frame_err <= 1'b0;
        end else begin
            rx_done <= 1'b0;
            if (evt.sel_rise) begin
                active <= 1'b0;
                half   <= 1'b0;
                cnt    <= '0;
            end else if (evt.sel_fall) begin
                active    <= 1'b1;
                half      <= 1'b0;
                cnt       <= '0;
                tx_sr     <= tx_byte;
                frame_err <= 1'b0;
            end else if (active) begin
                if (evt.lead) begin
                    if (cnt == CNT_FULL) begin
                        frame_err <= 1'b1;
                    end else begin
                        samp <= evt.din;
                        half <= 1'b1;
                    end
                end else if (evt.trail && half) begin
                    half  <= 1'b0;
                    tx_sr <= tx_next;
                    rx_sr <= rx_next;
                    cnt   <= cnt + 1'b1;
                    if (cnt == CNT_LAST) begin
                        rx_byte <= rx_next;
                        rx_done <= 1'b1;
                    end
                end
            end
        end
    end

    assign miso_oe = active;
    assign miso    = active & tx_bit;
endmodule

// File: rtl/spi0_slave.sv
module spi0_slave
    import spi0_pkg::*;
#(
    parameter int unsigned DATA_W     = SPI0_DATA_W,
    parameter int unsigned SYNC_DEPTH = SPI0_SYNC_DEPTH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_cpol,
    input  logic              cfg_lsb_first,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              rx_ack,
    input  logic              spsck,
    input  logic              mosi,
    input  logic              ss_n,
    output logic              miso,
    output logic              miso_oe,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_full,
    output logic              frame_err
);
    localparam int unsigned PIN_W = $bits(spi0_pins_t);

    spi0_pins_t raw_pins;
    spi0_pins_t sync_pins;
    spi0_evt_t  evt;
    logic       rx_done;

    assign raw_pins = '{sck: spsck, mosi: mosi, ss_n: ss_n};

    spi0_sync #(
        .W      (PIN_W),
        .STAGES (SYNC_DEPTH),
        .RST_VAL(SPI0_PINS_IDLE)
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d  (raw_pins),
        .q  (sync_pins)
    );

    spi0_edge u_edge (
        .clk (clk),
        .rst (rst),
        .cpol(cfg_cpol),
        .cur (sync_pins),
        .evt (evt)
    );

    spi0_shifter #(.W(DATA_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .lsb_first(cfg_lsb_first),
        .tx_byte  (tx_byte),
        .evt      (evt),
        .miso     (miso),
        .miso_oe  (miso_oe),
        .rx_byte  (rx_byte),
        .rx_done  (rx_done),
        .frame_err(frame_err)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_full <= 1'b0;
        end else if (rx_done) begin
            rx_full <= 1'b1;
        end else if (rx_ack) begin
            rx_full <= 1'b0;
        end
    end
endmodule

// File: rtl/spi0_slave_chk.sv
module spi0_slave_chk #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         rx_ack,
    input logic         miso,
    input logic         miso_oe,
    input logic [W-1:0] rx_byte,
    input logic         rx_full,
    input logic         frame_err
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!rx_full && !frame_err && !miso_oe));

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !miso_oe |-> !miso);

    // R6
    full_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_full && !rx_ack) |=> rx_full);

    // R6
    byte_only_on_done_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(rx_byte) |=> rx_full);

    // R8
    err_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(frame_err) |-> miso_oe);
endmodule

bind spi0_slave spi0_slave_chk #(.W(DATA_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .rx_ack   (rx_ack),
    .miso     (miso),
    .miso_oe  (miso_oe),
    .rx_byte  (rx_byte),
    .rx_full  (rx_full),
    .frame_err(frame_err)
);

// File: tb/tb_spi0_slave.sv
module tb_spi0_slave;
    localparam int HALF = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_cpol = 1'b0;
    logic       cfg_lsb_first = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic       rx_ack = 1'b0;
    logic       spsck = 1'b0;
    logic       mosi = 1'b0;
    logic       ss_n = 1'b1;
    logic       miso;
    logic       miso_oe;
    logic [7:0] rx_byte;
    logic       rx_full;
    logic       frame_err;

    int checks = 0;
    int errors = 0;

    // each entry: {cpol, lsb_first, tx, rx}
    localparam logic [17:0] VEC [0:5] = '{
        {2'b00, 8'hA5, 8'h3C},
        {2'b01, 8'h81, 8'h7E},
        {2'b10, 8'h5A, 8'hC3},
        {2'b11, 8'h01, 8'h80},
        {2'b00, 8'hFF, 8'h00},
        {2'b11, 8'h00, 8'hFF}
    };

    always #5 clk = ~clk;

    spi0_slave dut (
        .clk(clk), .rst(rst), .cfg_cpol(cfg_cpol), .cfg_lsb_first(cfg_lsb_first),
        .tx_byte(tx_byte), .rx_ack(rx_ack), .spsck(spsck), .mosi(mosi), .ss_n(ss_n),
        .miso(miso), .miso_oe(miso_oe), .rx_byte(rx_byte), .rx_full(rx_full),
        .frame_err(frame_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic set_mode(input logic cpol, input logic lsb);
        @(negedge clk);
        cfg_cpol = cpol;
        cfg_lsb_first = lsb;
        spsck = cpol;
        idle(8);
    endtask

    // clocks nbits bit times; returns the byte seen on miso and the first-bit level
    task automatic frame(input logic [7:0] tx, input logic [7:0] din, input int nbits,
                         output logic [7:0] got, output logic first_bit, output logic oe_seen);
        got = 8'h00;
        @(negedge clk);
        tx_byte = tx;
        ss_n = 1'b0;
        idle(HALF);
        first_bit = miso;
        oe_seen = miso_oe;
        for (int i = 0; i < nbits; i++) begin
            int idx;
            idx = cfg_lsb_first ? i : 7 - i;
            if (i < 8) begin
                got[idx] = miso;
                mosi = din[idx];
            end else begin
                mosi = 1'b1;
            end
            idle(HALF);
            spsck = ~cfg_cpol;
            idle(HALF);
            spsck = cfg_cpol;
            idle(HALF);
        end
        ss_n = 1'b1;
        idle(8);
    endtask

    task automatic ack();
        @(negedge clk);
        rx_ack = 1'b1;
        @(negedge clk);
        rx_ack = 1'b0;
        idle(2);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] got;
        logic       fb;
        logic       oe;
        idle(5);
        rst = 1'b0;
        idle(3);
        // R1 reset state
        chk("R1 miso_oe", {31'b0, miso_oe}, 0);
        chk("R1 rx_full", {31'b0, rx_full}, 0);
        chk("R1 frame_err", {31'b0, frame_err}, 0);
        chk("R1 rx_byte", {24'b0, rx_byte}, 0);
        chk("R7 miso idle", {31'b0, miso}, 0);

        for (int v = 0; v < 6; v++) begin
            logic [17:0] e;
            e = VEC[v];
            set_mode(e[17], e[16]);
            frame(e[15:8], e[7:0], 8, got, fb, oe);
            chk("R2 oe after select", {31'b0, oe}, 1);
            chk("R2 first bit", {31'b0, fb}, {31'b0, e[16] ? e[8] : e[15]});
            chk("R4 tx order", {24'b0, got}, {24'b0, e[15:8]});
            chk("R3 R5 rx byte", {24'b0, rx_byte}, {24'b0, e[7:0]});
            chk("R6 rx_full set", {31'b0, rx_full}, 1);
            chk("R7 oe after release", {31'b0, miso_oe}, 0);
            ack();
            chk("R6 rx_full cleared", {31'b0, rx_full}, 0);
        end

        // R8 nine bits with no select release
        set_mode(1'b0, 1'b0);
        frame(8'h00, 8'h96, 9, got, fb, oe);
        chk("R8 byte kept", {24'b0, rx_byte}, 32'h96);
        chk("R8 frame_err set", {31'b0, frame_err}, 1);
        idle(20);
        chk("R6 rx_full held", {31'b0, rx_full}, 1);
        ack();
        frame(8'h00, 8'h42, 8, got, fb, oe);
        chk("R8 frame_err cleared", {31'b0, frame_err}, 0);
        chk("R8 next byte", {24'b0, rx_byte}, 32'h42);
        ack();

        // R9 aborted transfer then a full one
        set_mode(1'b1, 1'b1);
        frame(8'h00, 8'hFF, 4, got, fb, oe);
        chk("R9 rx_full not set", {31'b0, rx_full}, 0);
        chk("R9 rx_byte unchanged", {24'b0, rx_byte}, 32'h42);
        frame(8'h00, 8'h3C, 8, got, fb, oe);
        chk("R9 fresh byte", {24'b0, rx_byte}, 32'h3C);
        chk("R9 rx_full set", {31'b0, rx_full}, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule